// File: doc/BRIEF.md
# Multichannel Moving-Sum Threshold Detector

The block watches many independent sample streams that arrive one after another on a single input port. Each channel has a running total over its most recent window of entries, and the block raises an alarm whenever that total reaches a programmable limit. Raw samples are first reduced: every group of eight consecutive samples on a channel is averaged into one entry. Only the averaged entries go into the window, so the window holds eight times fewer values.

All channels share one datapath and one history memory. The memory holds a circular buffer for each channel. For each averaged entry, the oldest entry is read back and the new one is written in its place. The running total is then updated by adding the new entry and subtracting the one that drops out, so the window is never summed from scratch. Each update produces a one-cycle result that carries the channel index, the new total and the alarm bit.

A controller with four states sequences the work. CLEAR runs after reset and zeroes every history word. IDLE accepts samples. FETCH reads the outgoing entry. UPDATE writes the incoming entry, updates the total and issues the result. The transitions are:

- CLEAR→IDLE on the last memory address.
- IDLE→FETCH when the accepted sample completes a group of eight.
- IDLE→IDLE on any other accepted sample.
- FETCH→UPDATE unconditionally.
- UPDATE→IDLE unconditionally.

Top module: `mswin_detect`

## Requirements
- R1: After reset the block stays in CLEAR for exactly NUM_CH*WIN_LEN cycles with `s_ready` low and no result. It then enters IDLE with `s_ready` high, and every window starts empty (zero).
- R2: Accepted samples belong to channels in strict round-robin order. The first accepted sample after reset is channel 0, and channel NUM_CH-1 is followed by channel 0.
- R3: For each channel, every 8 consecutive accepted samples form one entry equal to floor(sum of the 8 samples / 8). Only the 8th sample of a group produces a result.
- R4: The result sum for a channel is the total of its last WIN_LEN entries. Entries not yet written count as zero.
- R5: A full window of maximum entries (WIN_LEN*(2^SAMP_W-1)) fits the SAMP_W+log2(WIN_LEN)-bit sum without overflow.
- R6: `res_alarm` is 1 on a result exactly when `res_sum` is greater than or equal to the threshold register, and 0 otherwise.
- R7: The threshold register resets to all ones. A write through `thr_we` takes effect for the next update and leaves every channel's total and history untouched.
- R8: Channels are independent. Samples on one channel never change another channel's entries or total.
- R9: `res_valid` is a single-cycle pulse. After a group-completing sample is accepted, `s_ready` is low for the FETCH and UPDATE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Block can accept a sample (IDLE) |
| s_data | input | SAMP_W | Unsigned sample for the current round-robin channel |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | SAMP_W+log2(WIN_LEN) | New threshold value |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | log2(NUM_CH) | Channel of the result |
| res_sum | output | SAMP_W+log2(WIN_LEN) | Updated window total |
| res_alarm | output | 1 | Total at or above threshold |

## Verification
The bench builds the block with NUM_CH=4 and WIN_LEN=4. With these values the 16-word clear sequence is short, and every channel's circular buffer wraps after four averaged entries. A few dozen groups therefore exercise subtract-oldest against real history rather than zeros. The small window also lets all-255 input reach the maximum total of 1020 quickly, so the bench can place the threshold exactly at that total, and one above it, to check the equality boundary.

// File: rtl/mswin_pkg.sv
package mswin_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_FETCH  = 2'd2,
        ST_UPDATE = 2'd3
    } mswin_state_e;
endpackage

// File: rtl/mswin_grp_avg.sv
// Per-channel group-of-8 averaging ahead of the long window.
module mswin_grp_avg #(
    parameter int NUM_CH   = 16,
    parameter int SAMP_W   = 8,
    parameter int GRP_LOG2 = 3,
    parameter int CH_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [CH_W-1:0]   ch,
    input  logic [SAMP_W-1:0] sample,
    output logic              last_o,
    output logic [SAMP_W-1:0] avg_o
);
    localparam int GW = SAMP_W + GRP_LOG2;

    logic [GW-1:0]       acc_q [NUM_CH];
    logic [GRP_LOG2-1:0] cnt_q [NUM_CH];
    logic [GW-1:0]       tot;

    always_comb begin
        tot    = acc_q[ch] + GW'(sample);
        avg_o  = tot[GW-1:GRP_LOG2];
        last_o = (cnt_q[ch] == {GRP_LOG2{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                acc_q[i] <= '0;
                cnt_q[i] <= '0;
            end
        end else if (take) begin
            acc_q[ch] <= last_o ? '0 : tot;
            cnt_q[ch] <= cnt_q[ch] + 1'b1;
        end
    end

    // R3: a completed group restarts the channel's counter at zero
    assert_group_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last_o) |=> (cnt_q[$past(ch)] == '0));
endmodule

// File: rtl/mswin_hist_ram.sv
// History memory: one circular buffer per channel, synchronous read.
module mswin_hist_ram #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/mswin_acc_bank.sv
// Per-channel running totals and circular write pointers.
module mswin_acc_bank #(
    parameter int NUM_CH  = 16,
    parameter int WIN_LEN = 16,
    parameter int SAMP_W  = 8,
    parameter int SUM_W   = 12,
    parameter int CH_W    = 4,
    parameter int PTR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [CH_W-1:0]   upd_ch,
    input  logic [SAMP_W-1:0] add_val,
    input  logic [SAMP_W-1:0] sub_val,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [SUM_W-1:0]  sum_new_o
);
    localparam logic [SUM_W:0] SUM_MAX = (SUM_W+1)'(WIN_LEN * ((1 << SAMP_W) - 1));

    logic [NUM_CH-1:0][SUM_W-1:0] sum_q;
    logic [NUM_CH-1:0][PTR_W-1:0] ptr_q;

    always_comb begin
        ptr_o     = ptr_q[upd_ch];
        sum_new_o = sum_q[upd_ch] - SUM_W'(sub_val) + SUM_W'(add_val);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_q[g] <= '0;
                ptr_q[g] <= '0;
            end else if (upd_en && (upd_ch == CH_W'(g))) begin
                sum_q[g] <= sum_new_o;
                ptr_q[g] <= (ptr_q[g] == PTR_W'(WIN_LEN - 1)) ? '0 : ptr_q[g] + 1'b1;
            end
        end
    end

    // R5: a window of maximum entries never exceeds the representable bound
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> ({1'b0, sum_new_o} <= SUM_MAX));
endmodule

// File: rtl/mswin_detect.sv
module mswin_detect
    import mswin_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int SAMP_W   = 8,
    parameter int WIN_LEN  = 16,
    parameter int GRP_LOG2 = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                s_valid,
    output logic                                s_ready,
    input  logic [SAMP_W-1:0]                   s_data,
    input  logic                                thr_we,
    input  logic [SAMP_W+$clog2(WIN_LEN)-1:0]   thr_wdata,
    output logic                                res_valid,
    output logic [$clog2(NUM_CH)-1:0]           res_chan,
    output logic [SAMP_W+$clog2(WIN_LEN)-1:0]   res_sum,
    output logic                                res_alarm
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int PTR_W  = $clog2(WIN_LEN);
    localparam int SUM_W  = SAMP_W + PTR_W;
    localparam int DEPTH  = NUM_CH * WIN_LEN;
    localparam int ADDR_W = $clog2(DEPTH);

    mswin_state_e state_q, state_d;

    logic [CH_W-1:0]   rr_ch_q;
    logic [ADDR_W-1:0] clr_addr_q;
    logic [CH_W-1:0]   ch_q;
    logic [SAMP_W-1:0] avg_q;
    logic [SUM_W-1:0]  thr_q;

    logic              take;
    logic              grp_last;
    logic [SAMP_W-1:0] grp_avg;
    logic [PTR_W-1:0]  cur_ptr;
    logic [SUM_W-1:0]  sum_new;
    logic [ADDR_W-1:0] slot_addr;
    logic              ram_we, ram_re;
    logic [ADDR_W-1:0] ram_waddr;
    logic [SAMP_W-1:0] ram_wdata, ram_rdata;

    assign take      = s_valid && s_ready;
    assign slot_addr = ADDR_W'(ch_q) * ADDR_W'(WIN_LEN) + ADDR_W'(cur_ptr);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:  if (clr_addr_q == ADDR_W'(DEPTH - 1)) state_d = ST_IDLE;
            ST_IDLE:   if (s_valid && grp_last)              state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        s_ready   = 1'b0;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_waddr = slot_addr;
        ram_wdata = avg_q;
        unique case (state_q)
            ST_CLEAR: begin
                ram_we    = 1'b1;
                ram_waddr = clr_addr_q;
                ram_wdata = '0;
            end
            ST_IDLE:   s_ready = 1'b1;
            ST_FETCH:  ram_re  = 1'b1;
            ST_UPDATE: ram_we  = 1'b1;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ch_q    <= '0;
            clr_addr_q <= '0;
            ch_q       <= '0;
            avg_q      <= '0;
            thr_q      <= '1;
            res_valid  <= 1'b0;
            res_chan   <= '0;
            res_sum    <= '0;
            res_alarm  <= 1'b0;
        end else begin
            if (state_q == ST_CLEAR) clr_addr_q <= clr_addr_q + 1'b1;
            if (take) begin
                rr_ch_q <= (rr_ch_q == CH_W'(NUM_CH - 1)) ? '0 : rr_ch_q + 1'b1;
                if (grp_last) begin
                    ch_q  <= rr_ch_q;
                    avg_q <= grp_avg;
                end
            end
            if (thr_we) thr_q <= thr_wdata;
            res_valid <= (state_q == ST_UPDATE);
            res_alarm <= (state_q == ST_UPDATE) && (sum_new >= thr_q);
            if (state_q == ST_UPDATE) begin
                res_chan <= ch_q;
                res_sum  <= sum_new;
            end
        end
    end

    mswin_grp_avg #(
        .NUM_CH(NUM_CH), .SAMP_W(SAMP_W), .GRP_LOG2(GRP_LOG2), .CH_W(CH_W)
    ) u_grp (
        .clk(clk), .rst_n(rst_n), .take(take), .ch(rr_ch_q), .sample(s_data),
        .last_o(grp_last), .avg_o(grp_avg)
    );

    mswin_hist_ram #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DW(SAMP_W)
    ) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .re(ram_re), .raddr(slot_addr), .rdata(ram_rdata)
    );

    mswin_acc_bank #(
        .NUM_CH(NUM_CH), .WIN_LEN(WIN_LEN), .SAMP_W(SAMP_W),
        .SUM_W(SUM_W), .CH_W(CH_W), .PTR_W(PTR_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .upd_en(state_q == ST_UPDATE), .upd_ch(ch_q),
        .add_val(avg_q), .sub_val(ram_rdata), .ptr_o(cur_ptr), .sum_new_o(sum_new)
    );

    // R9: result strobe lasts one cycle
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R9: a group-completing sample makes the block busy on the next cycle
    assert_busy_after_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && grp_last) |=> !s_ready);
    // R1: no result while the history is being cleared
    assert_quiet_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |=> !res_valid);
    // R6: alarm matches the comparison with the threshold in force at update
    assert_alarm_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_alarm == (res_sum >= $past(thr_q))));
endmodule

// File: tb/mswin_detect_tb.sv
module mswin_detect_tb;
    localparam int NCH = 4;
    localparam int WL  = 4;
    localparam int SW  = 10;
    localparam int CW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_valid = 1'b0;
    logic s_ready;
    logic [7:0] s_data = '0;
    logic thr_we = 1'b0;
    logic [SW-1:0] thr_wdata = '0;
    logic res_valid;
    logic [CW-1:0] res_chan;
    logic [SW-1:0] res_sum;
    logic res_alarm;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk; // 125 MHz

    mswin_detect #(.NUM_CH(NCH), .SAMP_W(8), .WIN_LEN(WL), .GRP_LOG2(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .res_valid(res_valid),
        .res_chan(res_chan), .res_sum(res_sum), .res_alarm(res_alarm)
    );

    // Reference model state
    int gsum [NCH];
    int gcnt [NCH];
    int hist [NCH][WL];
    int hidx [NCH];
    int rr = 0;
    int thr_m = (1 << SW) - 1;
    logic [CW+SW:0] expq [$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int d);
        int ch;
        bit last;
        ch = rr;
        rr = (rr + 1) % NCH;
        last = (gcnt[ch] == 7);
        if (last) begin
            int avg, s;
            avg = (gsum[ch] + d) / 8;          // R3 floor average
            hist[ch][hidx[ch]] = avg;          // R4 oldest replaced
            hidx[ch] = (hidx[ch] + 1) % WL;
            s = 0;
            for (int k = 0; k < WL; k++) s += hist[ch][k];
            expq.push_back({CW'(ch), SW'(s), (s >= thr_m)});
            gsum[ch] = 0;
            gcnt[ch] = 0;
        end else begin
            gsum[ch] += d;
            gcnt[ch]++;
        end
        while (!s_ready) @(negedge clk);
        s_valid = 1'b1;
        s_data  = 8'(d);
        @(negedge clk);
        s_valid = 1'b0;
        if (last) check(s_ready == 1'b0, "R9 busy after group", int'(s_ready), 0);
    endtask

    task automatic set_thr(input int v);
        repeat (4) @(negedge clk);
        thr_we = 1'b1;
        thr_wdata = SW'(v);
        @(negedge clk);
        thr_we = 1'b0;
        thr_m = v;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected result", int'(res_sum), -1);
            end else begin
                logic [CW+SW:0] e;
                e = expq.pop_front();
                check(res_chan == e[CW+SW:SW+1], "R2 channel", int'(res_chan), int'(e[CW+SW:SW+1]));
                check(res_sum == e[SW:1], "R4/R8 sum", int'(res_sum), int'(e[SW:1]));
                check(res_alarm == e[0], "R6/R7 alarm", int'(res_alarm), int'(e[0]));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int n;
        for (int c = 0; c < NCH; c++) begin
            gsum[c] = 0; gcnt[c] = 0; hidx[c] = 0;
            for (int k = 0; k < WL; k++) hist[c][k] = 0;
        end
        repeat (3) @(negedge clk);
        check(s_ready == 1'b0, "R1 ready low in reset", int'(s_ready), 0);
        rst_n = 1'b1;
        n = 0;
        while (!s_ready) begin
            check(res_valid == 1'b0, "R1 no result while clearing", int'(res_valid), 0);
            @(negedge clk);
            n++;
        end
        check(n == NCH * WL, "R1 clear length", n, NCH * WL);

        // R3 truncation: samples 0..7 average to 3 on every channel
        for (int k = 0; k < 8; k++)
            for (int c = 0; c < NCH; c++) send(k);

        // Varied pattern, windows wrap (R4, R8), default threshold -> no alarm (R7)
        for (int r = 0; r < 48; r++)
            for (int c = 0; c < NCH; c++) send((c * 37 + r * 13 + (r % 5) * 50) & 8'hFF);

        // R7: mid-range threshold, totals continue undisturbed
        set_thr(300);
        for (int r = 0; r < 40; r++)
            for (int c = 0; c < NCH; c++) send((c == 2) ? 8'd250 : ((r * 29 + c * 7) & 8'h7F));

        // R5/R6: all-maximum input, threshold exactly at the full-window total
        set_thr(1020);
        for (int r = 0; r < 40; r++)
            for (int c = 0; c < NCH; c++) send(255);
        // R6 boundary: one above the maximum total never alarms
        set_thr(1021);
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < NCH; c++) send(255);
        // Threshold at zero: every result alarms
        set_thr(0);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < NCH; c++) send(0);

        repeat (10) @(negedge clk);
        check(expq.size() == 0, "R9 all results delivered", expq.size(), 0);
        finish_run();
    end
endmodule